// File: doc/BRIEF.md
# DRAM Access Command Sequencer

This block is the command-issuing state machine of a single-data-rate SDRAM controller. It runs only after the memory has been initialized. It serves two kinds of work: one read or write access at a time from a bus master, and periodic refresh. For every access it opens the addressed row with an ACTIVE command. It then issues a read or write that carries auto-precharge, so no row stays open once the access ends. The block times the activate-to-column delay, the CAS latency, the data burst, the write recovery (tDAL) and the refresh cycle time (tRFC) with one shared down-counter.

The surrounding controller turns the command code into the row and column strobes and the address pins. It uses the two data-phase enables to move data between the bus master and the memory. The refresh-interval timer outside this block holds a refresh request flag. This block pulses an acknowledge that clears that flag when the refresh command goes out.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, and whenever reset is asserted, the block is idle: the command code is NOP (0), both data enables are low, busy is low and the refresh acknowledge is low.
- R2: While `init_done` is low, the block stays idle whatever the other inputs do.
- R3: In idle with `init_done` high and `ref_req` high, the block issues REFRESH (code 4) for one cycle with `ref_ack` high. It then shows NOP for TRFC-1 cycles and returns to idle. A refresh request wins over a pending access.
- R4: In idle with `init_done` high, `ref_req` low and `adsn` low, the block issues ACTIVE (code 1) for one cycle, followed by TRCD-1 NOP cycles.
- R5: In the last cycle of the activate wait, `rd_wrn` is sampled. A value of 1 issues READ with auto-precharge (code 2), and 0 issues WRITE with auto-precharge (code 3). The value of `rd_wrn` at any other time has no effect.
- R6: After a read command, the block shows NOP for CL-1 cycles. It then holds `rd_en` high for BL cycles and returns to idle in the next cycle.
- R7: After a write command, `wr_en` is high for the next BL cycles. The block then waits TDAL NOP cycles with busy high and returns to idle.
- R8: `busy` is high exactly while the block is outside idle. While busy, `adsn`, `ref_req` and `init_done` are ignored.
- R9: `rd_en` and `wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_done | input | 1 | Memory initialization has completed |
| ref_req | input | 1 | Latched refresh request from the interval timer |
| adsn | input | 1 | Access strobe from the bus master, active low |
| rd_wrn | input | 1 | Access direction: 1 read, 0 write |
| cmd | output | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ-AP, 3 WRITE-AP, 4 REFRESH |
| rd_en | output | 1 | Read data phase enable |
| wr_en | output | 1 | Write data phase enable |
| busy | output | 1 | Request accepted and not yet finished |
| ref_ack | output | 1 | One-cycle pulse that clears the refresh request latch |

## Verification
A wrong state or counter value shows at the ports within one cycle. It appears as a command code in the wrong cycle, a data enable that is one cycle early or late or too long, or busy dropping before the wait ends. The bench compares every output in every cycle of scripted refresh, read and write traces. An off-by-one in any wait is therefore caught on the first cycle where the sequence diverges. A wrong priority or a leaked sample of an ignored input changes the next command code immediately.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REF, ST_RFC, ST_ACT, ST_RCD,
    ST_RDCMD, ST_CLW, ST_RDAT, ST_WRCMD, ST_WDAT, ST_DAL
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RDA = 3'd2,
    CMD_WRA = 3'd3,
    CMD_REF = 3'd4
  } dram_cmd_e;
endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int TRCD  = 3,
  parameter int CL    = 2,
  parameter int BL    = 4,
  parameter int TDAL  = 3,
  parameter int TRFC  = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             ref_req,
  input  logic             adsn,
  input  logic             rd_wrn,
  input  logic             tmr_zero,
  output seq_state_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  seq_state_e nxt;

  // Number of cycles a state lasts; zero for one-cycle command states.
  function automatic int hold_len(seq_state_e s);
    case (s)
      ST_RFC:           return TRFC - 1;
      ST_RCD:           return TRCD - 1;
      ST_CLW:           return CL - 1;
      ST_RDAT, ST_WDAT: return BL;
      ST_DAL:           return TDAL;
      default:          return 0;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (init_done) begin
                  if (ref_req)   nxt = ST_REF;
                  else if (!adsn) nxt = ST_ACT;
                end
      ST_REF:   nxt = ST_RFC;
      ST_RFC:   if (tmr_zero) nxt = ST_IDLE;
      ST_ACT:   nxt = ST_RCD;
      ST_RCD:   if (tmr_zero) nxt = rd_wrn ? ST_RDCMD : ST_WRCMD;
      ST_RDCMD: nxt = ST_CLW;
      ST_CLW:   if (tmr_zero) nxt = ST_RDAT;
      ST_RDAT:  if (tmr_zero) nxt = ST_IDLE;
      ST_WRCMD: nxt = ST_WDAT;
      ST_WDAT:  if (tmr_zero) nxt = ST_DAL;
      ST_DAL:   if (tmr_zero) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (nxt != state) && (hold_len(nxt) != 0);
  assign tmr_val  = CNT_W'(hold_len(nxt) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R5
  rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RCD && tmr_zero && rd_wrn) |=> (state == ST_RDCMD));
  // R2
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !init_done) |=> (state == ST_IDLE));
endmodule

// File: rtl/dram_seq_cmdgen.sv
module dram_seq_cmdgen
  import dram_seq_pkg::*;
(
  input  seq_state_e state,
  output logic [2:0] cmd,
  output logic       rd_en,
  output logic       wr_en,
  output logic       busy,
  output logic       ref_ack
);
  always_comb begin
    case (state)
      ST_REF:   cmd = CMD_REF;
      ST_ACT:   cmd = CMD_ACT;
      ST_RDCMD: cmd = CMD_RDA;
      ST_WRCMD: cmd = CMD_WRA;
      default:  cmd = CMD_NOP;
    endcase
  end

  assign rd_en   = (state == ST_RDAT);
  assign wr_en   = (state == ST_WDAT);
  assign busy    = (state != ST_IDLE);
  assign ref_ack = (state == ST_REF);
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int CL   = 2,
  parameter int BL   = 4,
  parameter int TDAL = 3,
  parameter int TRFC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       ref_req,
  input  logic       adsn,
  input  logic       rd_wrn,
  output logic [2:0] cmd,
  output logic       rd_en,
  output logic       wr_en,
  output logic       busy,
  output logic       ref_ack
);
  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_WAIT = max_of(max_of(max_of(TRCD, CL), max_of(BL, TDAL)), TRFC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  seq_state_e       state;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  dram_seq_ctrl #(
    .TRCD(TRCD), .CL(CL), .BL(BL), .TDAL(TDAL), .TRFC(TRFC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .ref_req(ref_req),
    .adsn(adsn), .rd_wrn(rd_wrn), .tmr_zero(tmr_zero), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  dram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  dram_seq_cmdgen u_cmdgen (
    .state(state), .cmd(cmd), .rd_en(rd_en), .wr_en(wr_en),
    .busy(busy), .ref_ack(ref_ack)
  );

  // R9
  excl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  // R3
  ref_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |=> (busy && cmd == CMD_NOP && !ref_ack));
  // R4
  act_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> (busy && cmd == CMD_NOP));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !busy) |=> !busy);
  // R7
  write_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> (busy && cmd == CMD_NOP));
  // R6
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> ($past(busy) && $past(cmd) == CMD_NOP));
endmodule

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_done = 1'b0, ref_req = 1'b0, adsn = 1'b1, rd_wrn = 1'b1;
  logic [2:0] cmd;
  logic       rd_en, wr_en, busy, ref_ack;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dram_cmd_seq #(.TRCD(3), .CL(2), .BL(4), .TDAL(3), .TRFC(5)) u_dram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .ref_req(ref_req),
    .adsn(adsn), .rd_wrn(rd_wrn), .cmd(cmd), .rd_en(rd_en), .wr_en(wr_en),
    .busy(busy), .ref_ack(ref_ack)
  );

  // {init, ref, adsn, rd_wrn, exp cmd[2:0], exp rd_en, exp wr_en, exp busy, exp ref_ack}
  localparam int NV = 36;
  localparam logic [10:0] VEC [NV] = '{
    11'b0101_000_0000, 11'b0000_000_0000,                       // R2
    11'b1101_100_0011, 11'b1001_000_0010, 11'b1001_000_0010,     // R3
    11'b1001_000_0010, 11'b1001_000_0010, 11'b1011_000_0000,
    11'b1001_001_0010, 11'b1010_000_0010, 11'b1010_000_0010,     // R4
    11'b1011_010_0010,                                           // R5
    11'b1111_000_0010,                                           // R8
    11'b1011_000_1010, 11'b1011_000_1010, 11'b1011_000_1010,     // R6
    11'b1011_000_1010, 11'b1011_000_0000,
    11'b1000_001_0010, 11'b1011_000_0010, 11'b1011_000_0010,     // R4
    11'b1010_011_0010,                                           // R5
    11'b1000_000_0110, 11'b1000_000_0110, 11'b1000_000_0110,     // R7
    11'b1000_000_0110, 11'b1100_000_0010, 11'b1100_000_0010,
    11'b1100_000_0010, 11'b1100_000_0000,
    11'b1100_100_0011, 11'b1011_000_0010, 11'b1011_000_0010,     // R3
    11'b1011_000_0010, 11'b1011_000_0010, 11'b1011_000_0000
  };

  function automatic string row_req(int i);
    if (i < 2)  return "R2";
    if (i < 8)  return "R3";
    if (i < 11) return "R4";
    if (i == 11) return "R5";
    if (i == 12) return "R8";
    if (i < 18) return "R6";
    if (i < 21) return "R4";
    if (i == 21) return "R5";
    if (i < 30) return "R7";
    return "R3";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(req, "cmd", int'(cmd), 0);
    check(req, "rd_en", int'(rd_en), 0);
    check(req, "wr_en", int'(wr_en), 0);
    check(req, "busy", int'(busy), 0);
    check(req, "ref_ack", int'(ref_ack), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_idle("R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R1");

    for (int i = 0; i < NV; i++) begin
      {init_done, ref_req, adsn, rd_wrn} = VEC[i][10:7];
      @(posedge clk); #1;
      check(row_req(i), "cmd", int'(cmd), int'(VEC[i][6:4]));
      check(row_req(i), "rd_en", int'(rd_en), int'(VEC[i][3]));
      check(row_req(i), "wr_en", int'(wr_en), int'(VEC[i][2]));
      check("R8", "busy", int'(busy), int'(VEC[i][1]));
      check(row_req(i), "ref_ack", int'(ref_ack), int'(VEC[i][0]));
      check("R9", "enables", int'(rd_en & wr_en), 0);
    end

    // R1: reset in the middle of a write burst returns to idle
    {init_done, ref_req, adsn, rd_wrn} = 4'b1000;
    repeat (5) @(posedge clk);
    #1;
    check("R7", "wr_en before reset", int'(wr_en), 1);
    rst_n = 1'b0;
    #2;
    check_idle("R1");
    adsn = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R1");

    // R5: direction read back-to-back after idle, with rd_wrn low at the strobe
    {init_done, ref_req, adsn, rd_wrn} = 4'b1000;
    @(posedge clk); #1;
    check("R4", "cmd", int'(cmd), 1);
    adsn = 1'b1; rd_wrn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R5", "cmd", int'(cmd), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule